// File: doc/BRIEF.md
# Epoch Checkpoint Remapping Controller

This controller gives a hybrid memory (a small fast volatile tier in front of a large persistent tier) crash consistency without any change to software. Time runs in epochs. During an epoch, each load or store names a logical block. The controller answers with the physical place that serves it: the fast-tier frame of a hot page, one of three persistent slots of a cold block, or a persistent checkpoint copy of a hot page. A store to a cold block never lands on the slot that holds the last checkpoint. It goes to a spare slot, and a small working table records the new slot, so no data is copied.

When an epoch ends, the working table becomes the in-flight table. The dirty hot pages are then written back one at a time into the persistent page copy that is not the committed one. Requests keep flowing while this happens. Once the last writeback is acknowledged, the in-flight slots and page copies are promoted in a single cycle. A crash pulse discards everything that was not committed. A separate classifier chooses which pages are hot; it supplies that choice as a static input vector, and the controller only uses it.

Top module: `ecr_ctrl`

## Requirements
- R1: After reset, `req_stall`, `rsp_valid`, `wb_valid`, `ckpt_busy` and `commit_done` are 0. Every cold block resolves to slot 0, and every hot page resolves to its fast frame.
- R2: A request is accepted in a cycle with `req_valid`=1, `req_stall`=0 and `crash_recover`=0. Its response appears with `rsp_valid`=1 in the next cycle. `rsp_kind` is 0 for a fast frame (`rsp_loc`={addr,00}), 1 for a persistent block slot (`rsp_loc`={addr,slot}) and 2 for a persistent page copy (`rsp_loc`={addr,0,copy}).
- R3: A store to a cold block with no working entry takes the lowest slot in 0..2 that is neither the committed slot nor the in-flight slot. A second store to that block in the same epoch reuses the slot.
- R4: A load of a cold block returns the working slot if one exists. Otherwise it returns the in-flight slot if one exists. Otherwise it returns the committed slot.
- R5: An epoch end with no checkpoint running raises `ckpt_busy` on the next cycle. The working entries move to the in-flight table. Each dirty hot page is issued on `wb_valid`, lowest page first, with `wb_sel` equal to the complement of that page's committed copy.
- R6: `wb_valid`, `wb_page` and `wb_sel` hold until `wb_ack`. Only one writeback is outstanding at a time.
- R7: A checkpoint commits only after every one of its writebacks has been acknowledged. On commit, `commit_done` pulses for one cycle, `ckpt_busy` falls, and the in-flight slots and page copies become the committed ones.
- R8: Requests are accepted, without stall, while a checkpoint is running.
- R9: An epoch end that arrives while a checkpoint is running raises `req_stall` from the next cycle. The stall lasts until that checkpoint commits and the delayed epoch end has started a new checkpoint.
- R10: The store that fills the last of MAX_ENT working entries raises `req_stall` in the next cycle, and the epoch then ends on its own.
- R11: A `crash_recover` pulse drops all working and in-flight state and cancels the writeback. After it, `ckpt_busy`, `wb_valid` and `req_stall` are 0, and every cold block resolves to its committed slot.
- R12: After a crash, a load of a hot page returns its committed persistent copy (kind 2). This lasts until the page is stored to again; after that store, loads return the fast frame.
- R13: A request presented while `req_stall`=1 gets no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_hot | input | N_PAGES | Per-page hot flag from the classifier |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | LA_W | Logical block address {page, block} |
| req_stall | output | 1 | Requests are not accepted |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | 0 fast frame, 1 block slot, 2 page copy |
| rsp_loc | output | LA_W+2 | Resolved physical location |
| epoch_end | input | 1 | End the current epoch |
| crash_recover | input | 1 | Discard uncommitted state |
| wb_valid | output | 1 | Page writeback command pending |
| wb_page | output | PG_W | Page to write back |
| wb_sel | output | 1 | Persistent page copy to write |
| wb_ack | input | 1 | Writeback finished |
| ckpt_busy | output | 1 | A checkpoint is in flight |
| commit_done | output | 1 | One-cycle pulse when a checkpoint commits |

## Verification
Some properties are checked on every cycle. An accepted request always answers one cycle later, and a stalled one never does. A writeback command stays stable until it is acknowledged, and it appears only while a checkpoint runs. A commit pulse never coincides with a pending writeback. A crash always leaves the controller idle, and the response codes and slot numbers stay legal. Other behaviours can only be shown by the directed scenarios, which compare concrete resolved locations. These are the slot choice that avoids both older versions, the working-over-in-flight-over-committed priority, the promotion at commit, the roll-back to committed locations after a crash (including in the middle of a checkpoint), the delayed epoch end, the forced end when the table fills, and the ignored store under stall.

// File: rtl/ecr_pkg.sv
package ecr_pkg;

  typedef enum logic [1:0] {
    LK_FAST  = 2'd0,
    LK_BLOCK = 2'd1,
    LK_PAGE  = 2'd2
  } loc_kind_t;

  // Lowest of the three persistent slots that is neither the committed one
  // nor the one held by the in-flight epoch.
  function automatic logic [1:0] pick_slot(input logic [1:0] cmt,
                                           input logic       fl_hit,
                                           input logic [1:0] fl_slot);
    logic [1:0] r;
    r = 2'd0;
    for (int s = 2; s >= 0; s--) begin
      if (2'(s) != cmt && !(fl_hit && 2'(s) == fl_slot)) r = 2'(s);
    end
    return r;
  endfunction

endpackage

// File: rtl/ecr_remap_table.sv
module ecr_remap_table #(
  parameter int LA_W    = 5,
  parameter int MAX_ENT = 4,
  parameter int CNT_W   = $clog2(MAX_ENT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             crash,
  input  logic [LA_W-1:0]  lk_addr,
  output logic             w_hit,
  output logic [1:0]       w_slot,
  output logic             c_hit,
  output logic [1:0]       c_slot,
  output logic [1:0]       m_slot,
  input  logic             ins_en,
  input  logic [1:0]       ins_slot,
  input  logic             flip,
  input  logic             commit,
  output logic [CNT_W-1:0] wcount
);
  localparam int N_LBLK = 1 << LA_W;
  localparam int IDX_W  = (MAX_ENT > 1) ? $clog2(MAX_ENT) : 1;

  logic            bank_q;
  logic            ent_v [2][MAX_ENT];
  logic [LA_W-1:0] ent_a [2][MAX_ENT];
  logic [1:0]      ent_s [2][MAX_ENT];
  logic [1:0]      cmt_q [N_LBLK];

  // Associative search over both banks; the working bank is bank_q.
  always_comb begin
    w_hit  = 1'b0;
    w_slot = 2'd0;
    c_hit  = 1'b0;
    c_slot = 2'd0;
    for (int i = 0; i < MAX_ENT; i++) begin
      if (ent_v[bank_q][i] && ent_a[bank_q][i] == lk_addr) begin
        w_hit  = 1'b1;
        w_slot = ent_s[bank_q][i];
      end
      if (ent_v[~bank_q][i] && ent_a[~bank_q][i] == lk_addr) begin
        c_hit  = 1'b1;
        c_slot = ent_s[~bank_q][i];
      end
    end
    m_slot = cmt_q[lk_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= 1'b0;
      wcount <= '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < MAX_ENT; i++) ent_v[b][i] <= 1'b0;
      for (int a = 0; a < N_LBLK; a++) cmt_q[a] <= 2'd0;
    end else if (crash) begin
      wcount <= '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < MAX_ENT; i++) ent_v[b][i] <= 1'b0;
    end else begin
      if (ins_en) begin
        ent_v[bank_q][wcount[IDX_W-1:0]] <= 1'b1;
        ent_a[bank_q][wcount[IDX_W-1:0]] <= lk_addr;
        ent_s[bank_q][wcount[IDX_W-1:0]] <= ins_slot;
        wcount <= wcount + 1'b1;
      end
      if (flip) begin
        bank_q <= ~bank_q;
        wcount <= '0;
      end
      if (commit) begin
        for (int i = 0; i < MAX_ENT; i++) begin
          if (ent_v[~bank_q][i]) cmt_q[ent_a[~bank_q][i]] <= ent_s[~bank_q][i];
          ent_v[~bank_q][i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/ecr_page_track.sv
module ecr_page_track #(
  parameter int N_PAGES = 8,
  parameter int PG_W    = $clog2(N_PAGES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               crash,
  input  logic               st_en,
  input  logic [PG_W-1:0]    st_page,
  input  logic               boundary,
  input  logic               commit,
  input  logic               wb_ack,
  output logic               wb_valid,
  output logic [PG_W-1:0]    wb_page,
  output logic               wb_sel,
  output logic               flush_done,
  output logic [N_PAGES-1:0] pg_sel,
  output logic [N_PAGES-1:0] stale
);
  logic [N_PAGES-1:0] dirty_q, flush_q, ckpt_q, st_vec;
  logic [PG_W-1:0]    nxt_pg;

  always_comb begin
    st_vec = '0;
    if (st_en) st_vec[st_page] = 1'b1;
    nxt_pg = '0;
    for (int i = N_PAGES - 1; i >= 0; i--) begin
      if (flush_q[i]) nxt_pg = PG_W'(i);
    end
  end

  assign flush_done = (flush_q == '0) && !wb_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      dirty_q  <= '0;
      flush_q  <= '0;
      ckpt_q   <= '0;
      pg_sel   <= '0;
      stale    <= '0;
      wb_valid <= 1'b0;
      wb_page  <= '0;
      wb_sel   <= 1'b0;
    end else if (crash) begin
      dirty_q  <= '0;
      flush_q  <= '0;
      ckpt_q   <= '0;
      stale    <= '1;
      wb_valid <= 1'b0;
    end else begin
      stale   <= stale & ~st_vec;
      dirty_q <= boundary ? '0 : (dirty_q | st_vec);
      if (boundary) begin
        flush_q <= dirty_q | st_vec;
        ckpt_q  <= dirty_q | st_vec;
      end
      if (wb_valid && wb_ack) begin
        wb_valid         <= 1'b0;
        flush_q[wb_page] <= 1'b0;
      end else if (!wb_valid && flush_q != '0) begin
        wb_valid <= 1'b1;
        wb_page  <= nxt_pg;
        wb_sel   <= ~pg_sel[nxt_pg];
      end
      if (commit) begin
        pg_sel <= pg_sel ^ ckpt_q;
        ckpt_q <= '0;
      end
    end
  end

endmodule

// File: rtl/ecr_epoch_ctl.sv
module ecr_epoch_ctl (
  input  logic clk,
  input  logic rst,
  input  logic crash,
  input  logic epoch_end,
  input  logic full_now,
  input  logic full_next,
  input  logic flush_done,
  output logic boundary,
  output logic commit,
  output logic busy,
  output logic stall,
  output logic commit_done
);
  logic pend_q, pend_n, end_evt;

  assign end_evt  = epoch_end | pend_q | full_now;
  assign boundary = !crash && end_evt && !busy;
  assign commit   = !crash && busy && flush_done;
  assign pend_n   = !crash && !boundary && (pend_q || epoch_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      busy        <= 1'b0;
      stall       <= 1'b0;
      commit_done <= 1'b0;
    end else begin
      pend_q      <= pend_n;
      stall       <= !crash && (pend_n || full_next);
      commit_done <= commit;
      if (crash)         busy <= 1'b0;
      else if (boundary) busy <= 1'b1;
      else if (commit)   busy <= 1'b0;
    end
  end

endmodule

// File: rtl/ecr_ctrl.sv
module ecr_ctrl #(
  parameter int N_PAGES      = 8,
  parameter int BLK_PER_PAGE = 4,
  parameter int MAX_ENT      = 4,
  parameter int PG_W         = $clog2(N_PAGES),
  parameter int BLK_W        = $clog2(BLK_PER_PAGE),
  parameter int LA_W         = PG_W + BLK_W,
  parameter int LOC_W        = LA_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PAGES-1:0] page_hot,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [LA_W-1:0]    req_addr,
  output logic               req_stall,
  output logic               rsp_valid,
  output logic [1:0]         rsp_kind,
  output logic [LOC_W-1:0]   rsp_loc,
  input  logic               epoch_end,
  input  logic               crash_recover,
  output logic               wb_valid,
  output logic [PG_W-1:0]    wb_page,
  output logic               wb_sel,
  input  logic               wb_ack,
  output logic               ckpt_busy,
  output logic               commit_done
);
  import ecr_pkg::*;
  localparam int CNT_W = $clog2(MAX_ENT + 1);

  logic             acc, hot, st_hot, ins_en;
  logic [PG_W-1:0]  page;
  logic             w_hit, c_hit;
  logic [1:0]       w_slot, c_slot, m_slot, new_slot, blk_slot;
  logic [CNT_W-1:0] wcount;
  logic             boundary, commit, flush_done, full_now, full_next;
  logic [N_PAGES-1:0] pg_sel, stale;
  loc_kind_t        kind_d;
  logic [LOC_W-1:0] loc_d;

  assign acc      = req_valid && !req_stall && !crash_recover;
  assign page     = req_addr[LA_W-1:BLK_W];
  assign hot      = page_hot[page];
  assign new_slot = pick_slot(m_slot, c_hit, c_slot);
  assign st_hot   = acc && req_we && hot;
  assign ins_en   = acc && req_we && !hot && !w_hit;
  assign full_now = (wcount == CNT_W'(MAX_ENT));
  assign full_next = !boundary &&
                     ((wcount + CNT_W'(ins_en)) == CNT_W'(MAX_ENT));

  ecr_remap_table #(.LA_W(LA_W), .MAX_ENT(MAX_ENT), .CNT_W(CNT_W)) u_tbl (
    .clk(clk), .rst(rst), .crash(crash_recover), .lk_addr(req_addr),
    .w_hit(w_hit), .w_slot(w_slot), .c_hit(c_hit), .c_slot(c_slot),
    .m_slot(m_slot), .ins_en(ins_en), .ins_slot(new_slot),
    .flip(boundary), .commit(commit), .wcount(wcount)
  );

  ecr_page_track #(.N_PAGES(N_PAGES), .PG_W(PG_W)) u_pg (
    .clk(clk), .rst(rst), .crash(crash_recover), .st_en(st_hot),
    .st_page(page), .boundary(boundary), .commit(commit), .wb_ack(wb_ack),
    .wb_valid(wb_valid), .wb_page(wb_page), .wb_sel(wb_sel),
    .flush_done(flush_done), .pg_sel(pg_sel), .stale(stale)
  );

  ecr_epoch_ctl u_ctl (
    .clk(clk), .rst(rst), .crash(crash_recover), .epoch_end(epoch_end),
    .full_now(full_now), .full_next(full_next), .flush_done(flush_done),
    .boundary(boundary), .commit(commit), .busy(ckpt_busy),
    .stall(req_stall), .commit_done(commit_done)
  );

  // Location resolution: working, then in-flight, then committed.
  always_comb begin
    if (req_we) blk_slot = w_hit ? w_slot : new_slot;
    else        blk_slot = w_hit ? w_slot : (c_hit ? c_slot : m_slot);
    if (hot) begin
      if (!req_we && stale[page]) begin
        kind_d = LK_PAGE;
        loc_d  = {req_addr, 1'b0, pg_sel[page]};
      end else begin
        kind_d = LK_FAST;
        loc_d  = {req_addr, 2'b00};
      end
    end else begin
      kind_d = LK_BLOCK;
      loc_d  = {req_addr, blk_slot};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= 2'd0;
      rsp_loc   <= '0;
    end else begin
      rsp_valid <= acc;
      if (acc) begin
        rsp_kind <= kind_d;
        rsp_loc  <= loc_d;
      end
    end
  end

endmodule

// File: rtl/ecr_ctrl_chk.sv
module ecr_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_stall,
  input logic       rsp_valid,
  input logic [1:0] rsp_kind,
  input logic [1:0] rsp_slot,
  input logic       crash_recover,
  input logic       wb_valid,
  input logic       wb_ack,
  input logic       wb_page_0,
  input logic       ckpt_busy,
  input logic       commit_done
);
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_stall && !crash_recover) |=> rsp_valid); // R2
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_kind != 2'd3); // R2
  AST_SLOT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'd1) |-> rsp_slot != 2'd3); // R3
  AST_WB_IN_CKPT: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> ckpt_busy); // R5
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ack && !crash_recover) |=> (wb_valid && $stable(wb_page_0))); // R6
  AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    commit_done |-> (!wb_valid && !ckpt_busy)); // R7
  AST_CRASH_IDLE: assert property (@(posedge clk) disable iff (rst)
    crash_recover |=> (!ckpt_busy && !wb_valid && !req_stall)); // R11
  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (rst)
    (req_stall && !crash_recover) |=> !rsp_valid); // R13
endmodule

bind ecr_ctrl ecr_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_stall(req_stall),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_slot(rsp_loc[1:0]),
  .crash_recover(crash_recover), .wb_valid(wb_valid), .wb_ack(wb_ack),
  .wb_page_0(wb_page[0]), .ckpt_busy(ckpt_busy), .commit_done(commit_done)
);

// File: tb/sim_ecr_ctrl.sv
module sim_ecr_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] page_hot = 8'b0000_1010;
  logic       req_valid = 1'b0, req_we = 1'b0;
  logic [4:0] req_addr = '0;
  logic       req_stall, rsp_valid, wb_valid, wb_sel, ckpt_busy, commit_done;
  logic [1:0] rsp_kind;
  logic [6:0] rsp_loc;
  logic [2:0] wb_page;
  logic       epoch_end = 1'b0, crash_recover = 1'b0, wb_ack = 1'b0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ecr_ctrl u0 (
    .clk(clk), .rst(rst), .page_hot(page_hot), .req_valid(req_valid),
    .req_we(req_we), .req_addr(req_addr), .req_stall(req_stall),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_loc(rsp_loc),
    .epoch_end(epoch_end), .crash_recover(crash_recover),
    .wb_valid(wb_valid), .wb_page(wb_page), .wb_sel(wb_sel), .wb_ack(wb_ack),
    .ckpt_busy(ckpt_busy), .commit_done(commit_done)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // One request cycle; response sampled at the following falling edge.
  task automatic do_req(input logic we, input int addr);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = 5'(addr);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic expect_rsp(string tag, input logic we, input int addr,
                            input int kind, input int loc);
    do_req(we, addr);
    check({tag, " valid"}, int'(rsp_valid), 1);
    check({tag, " kind"}, int'(rsp_kind), kind);
    check({tag, " loc"}, int'(rsp_loc), loc);
  endtask

  task automatic pulse_end();
    @(negedge clk) epoch_end = 1'b1;
    @(negedge clk) epoch_end = 1'b0;
  endtask

  task automatic pulse_crash();
    @(negedge clk) crash_recover = 1'b1;
    @(negedge clk) crash_recover = 1'b0;
  endtask

  task automatic ack_wb();
    @(negedge clk) wb_ack = 1'b1;
    @(negedge clk) wb_ack = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 20 && ckpt_busy; i++) @(negedge clk);
    check("R7 checkpoint drained", int'(ckpt_busy), 0);
  endtask

  task automatic t_reset();
    check("R1 stall", int'(req_stall), 0);
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 wb_valid", int'(wb_valid), 0);
    check("R1 busy", int'(ckpt_busy), 0);
    check("R1 commit_done", int'(commit_done), 0);
    expect_rsp("R1 cold load", 1'b0, 2, 1, 8);
    expect_rsp("R1 hot load", 1'b0, 5, 0, 20);
  endtask

  task automatic t_remap();
    expect_rsp("R3 first store", 1'b1, 2, 1, 9);
    expect_rsp("R3 repeat store", 1'b1, 2, 1, 9);
    expect_rsp("R4 load working", 1'b0, 2, 1, 9);
    expect_rsp("R4 load committed", 1'b0, 3, 1, 12);
  endtask

  task automatic t_epoch();
    expect_rsp("R2 hot store p3", 1'b1, 13, 0, 52);
    expect_rsp("R2 hot store p1", 1'b1, 4, 0, 16);
    pulse_end();
    check("R5 busy raised", int'(ckpt_busy), 1);
    @(negedge clk);
    check("R5 wb issued", int'(wb_valid), 1);
    check("R5 lowest page", int'(wb_page), 1);
    check("R5 other copy", int'(wb_sel), 1);
    expect_rsp("R3 avoid both", 1'b1, 2, 1, 10);
    check("R8 no stall in ckpt", int'(req_stall), 0);
    expect_rsp("R4 working over inflight", 1'b0, 2, 1, 10);
    expect_rsp("R8 store in ckpt", 1'b1, 3, 1, 13);
    check("R6 wb held", int'(wb_valid), 1);
    check("R6 wb page held", int'(wb_page), 1);
    check("R7 no early commit", int'(commit_done), 0);
    ack_wb();
    check("R6 wb dropped on ack", int'(wb_valid), 0);
    @(negedge clk);
    check("R5 second wb", int'(wb_valid), 1);
    check("R5 second page", int'(wb_page), 3);
    check("R7 still busy", int'(ckpt_busy), 1);
    ack_wb();
    check("R7 busy before commit", int'(ckpt_busy), 1);
    @(negedge clk);
    check("R7 commit pulse", int'(commit_done), 1);
    check("R7 busy low", int'(ckpt_busy), 0);
    @(negedge clk);
    check("R7 pulse one cycle", int'(commit_done), 0);
  endtask

  task automatic t_crash();
    pulse_crash();
    check("R11 idle", int'(ckpt_busy), 0);
    expect_rsp("R11 promoted slot", 1'b0, 2, 1, 9);
    expect_rsp("R11 working dropped", 1'b0, 3, 1, 12);
    expect_rsp("R12 p1 copy", 1'b0, 4, 2, 17);
    expect_rsp("R12 p3 copy", 1'b0, 13, 2, 53);
    expect_rsp("R12 store refills", 1'b1, 4, 0, 16);
    expect_rsp("R12 fast again", 1'b0, 4, 0, 16);
  endtask

  task automatic t_pend();
    bit seen;
    pulse_end();
    @(negedge clk);
    check("R5 wb sel flips", int'(wb_sel), 0);
    pulse_end();
    check("R9 stall raised", int'(req_stall), 1);
    do_req(1'b1, 1);
    check("R13 no response", int'(rsp_valid), 0);
    ack_wb();
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      if (!req_stall) begin seen = 1; break; end
      @(negedge clk);
    end
    check("R9 stall released", int'(seen), 1);
    check("R9 delayed end started", int'(ckpt_busy), 1);
    settle();
    expect_rsp("R13 store ignored", 1'b0, 1, 1, 4);
  endtask

  task automatic t_full();
    expect_rsp("R10 fill 1", 1'b1, 8, 1, 33);
    expect_rsp("R10 fill 2", 1'b1, 9, 1, 37);
    expect_rsp("R10 fill 3", 1'b1, 10, 1, 41);
    check("R10 no stall yet", int'(req_stall), 0);
    expect_rsp("R10 fill 4", 1'b1, 11, 1, 45);
    check("R10 stall on full", int'(req_stall), 1);
    @(negedge clk);
    check("R10 forced end", int'(ckpt_busy), 1);
    check("R10 stall drops", int'(req_stall), 0);
    settle();
    expect_rsp("R7 forced commit", 1'b0, 8, 1, 33);
  endtask

  task automatic t_crash_mid();
    expect_rsp("R3 cold store", 1'b1, 0, 1, 1);
    expect_rsp("R2 hot store p3", 1'b1, 12, 0, 48);
    pulse_end();
    @(negedge clk);
    check("R5 p3 wb", int'(wb_page), 3);
    check("R5 p3 sel", int'(wb_sel), 0);
    pulse_crash();
    check("R11 wb cancelled", int'(wb_valid), 0);
    check("R11 busy cleared", int'(ckpt_busy), 0);
    check("R11 stall cleared", int'(req_stall), 0);
    expect_rsp("R11 inflight dropped", 1'b0, 0, 1, 0);
    expect_rsp("R12 old copy kept", 1'b0, 12, 2, 49);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_remap();
    t_epoch();
    t_crash();
    t_pend();
    t_full();
    t_crash_mid();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule